// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block carries out the four partial-word operations that let a processor read or write a 32-bit word at any byte address on a little-endian bus. A left or right load reads the aligned word that contains the addressed byte. It then combines some bytes of that word with the bytes of the destination register that are kept, and returns the result for write-back. A left or right store reads the aligned word, replaces the selected byte lanes with bytes taken from the store data, and writes the merged word back.

A request is offered with an opcode, an effective address, a destination register index and a data word. For a load the data word is the current destination register value; for a store it is the store data. The unit then runs its own bus sequence. A one-cycle read request is followed by a wait for read data, which may arrive in the same cycle as the request. A store then holds a write request until it is acknowledged. A single-cycle completion pulse marks the end of each operation. The unit accepts a new request only while it is idle, and it is idle again in the cycle of that pulse.

Top module: `unaligned_merge_unit`

## Requirements
- R1: Every read and write the unit issues uses the effective address with its two low bits cleared, and the same address is used for the read and the write of one store.
- R2: Opcode 0x22 is the left load. With shift s equal to 8 times the low two address bits, the result is (reg AND (0x00FFFFFF >> s)) OR (mem << (24 - s)).
- R3: Opcode 0x26 is the right load. The result is (reg AND (0xFFFFFF00 << (24 - s))) OR (mem >> s).
- R4: Opcode 0x2A is the left store. The word written is (data >> (24 - s)) OR (mem AND (0xFFFFFF00 << s)).
- R5: Opcode 0x2E is the right store. The word written is (data << s) OR (mem AND (0x00FFFFFF >> (24 - s))).
- R6: The left load at byte offset 3 and the right load at byte offset 0 return the memory word unchanged. The left store at offset 3 and the right store at offset 0 write the data word unchanged.
- R7: A load whose destination index is 0 still issues its read and its completion pulse, but the register write enable stays low.
- R8: The read request lasts exactly one cycle and is never high together with the write request. A store holds its write request, with the address and data stable, until the acknowledge. A load's completion, with its register write, comes in the cycle after the read data is taken.
- R9: Any opcode other than the four above is ignored: no read, no write, no completion pulse, and the unit stays ready.
- R10: Read data presented in the same cycle as the read request is accepted. A write acknowledge presented in the same cycle as the first cycle of the write request completes the store, with the completion pulse in the following cycle.
- R11: The completion pulse lasts one cycle. Ready is high exactly while no operation is in progress, and a request presented in the cycle of the completion pulse is accepted.
- R12: After reset the unit is ready, and read request, write request, register write enable and completion are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_op | input | 6 | Operation code |
| req_addr | input | AW (32) | Effective byte address |
| req_dst | input | IDX_W (5) | Destination register index for loads |
| req_data | input | DATA_W (32) | Current register value (load) or store data (store) |
| req_ready | output | 1 | Unit idle; a valid request is taken this cycle |
| mem_rd_req | output | 1 | Read request, one cycle |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_addr | output | AW (32) | Aligned word address |
| mem_wr_data | output | DATA_W (32) | Merged word to write |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W (32) | Aligned word read from memory |
| mem_wr_ack | input | 1 | Write accepted |
| ld_we | output | 1 | Register write enable for a load result |
| ld_dst | output | IDX_W (5) | Register index to write |
| ld_data | output | DATA_W (32) | Merged load result |
| done | output | 1 | Completion pulse |

## Verification
Two pairs of events can fall in the same cycle. The completion pulse of one operation can coincide with the acceptance of the next request. Read data can arrive while the read request is still high, and in the same way a write acknowledge can arrive while the write request is still high. The bench provokes these cases with random read and acknowledge latencies that include zero, and with requests offered at the exact sample point where the completion pulse is seen. For the back-to-back case it then checks that the next read request appears one cycle later with the new aligned address. For the zero-latency cases it checks that the merged word and the completion appear at the same points as with a delayed response.

// File: rtl/umu_pkg.sv
// Shared types and opcode values for the unaligned word merge unit.
// Assumes a little-endian byte order on the memory bus.
package umu_pkg;

    // Which of the four merge patterns applies
    typedef enum logic [1:0] {
        MK_LOAD_LEFT   = 2'd0,
        MK_LOAD_RIGHT  = 2'd1,
        MK_STORE_LEFT  = 2'd2,
        MK_STORE_RIGHT = 2'd3
    } merge_kind_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WAIT = 2'd2,
        ST_WR   = 2'd3
    } seq_state_e;

    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] OPC_LOAD_LEFT   = 6'h22;
    localparam logic [OPC_W-1:0] OPC_LOAD_RIGHT  = 6'h26;
    localparam logic [OPC_W-1:0] OPC_STORE_LEFT  = 6'h2A;
    localparam logic [OPC_W-1:0] OPC_STORE_RIGHT = 6'h2E;

endpackage

// File: rtl/umu_op_decode.sv
// Opcode decoder: recognises the four partial-word opcodes and reports
// the merge pattern and whether a write-back to memory follows.
// Assumes every other opcode must be ignored by the sequencer.
module umu_op_decode
    import umu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             hit,
    output logic             is_store,
    output merge_kind_e      kind
);

    // Map opcode to pattern; unknown codes clear hit
    always_comb begin
        hit      = 1'b1;
        is_store = 1'b0;
        kind     = MK_LOAD_LEFT;
        case (opcode)
            OPC_LOAD_LEFT:   kind = MK_LOAD_LEFT;
            OPC_LOAD_RIGHT:  kind = MK_LOAD_RIGHT;
            OPC_STORE_LEFT:  begin kind = MK_STORE_LEFT;  is_store = 1'b1; end
            OPC_STORE_RIGHT: begin kind = MK_STORE_RIGHT; is_store = 1'b1; end
            default:         hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/umu_lane_merge.sv
// Byte-lane merge network. Each output lane picks either a register byte
// or a memory byte, chosen by the merge pattern and the byte offset.
// Assumes NB is a power of two; lane 0 is the least significant byte.
module umu_lane_merge
    import umu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OW    = $clog2(NB)
) (
    input  merge_kind_e       kind,
    input  logic [OW-1:0]     off,
    input  logic [DATA_W-1:0] reg_word,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] merged
);

    logic [7:0] reg_b [NB];
    logic [7:0] mem_b [NB];

    // Split both words into byte lanes
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            reg_b[i] = reg_word[i*8 +: 8];
            mem_b[i] = mem_word[i*8 +: 8];
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] pick;

        // Select the source byte for this lane
        always_comb begin : p_pick
            int o;
            o = int'(off);
            case (kind)
                MK_LOAD_LEFT:
                    pick = (g + o >= NB - 1) ? mem_b[OW'(g + o - (NB - 1))] : reg_b[g];
                MK_LOAD_RIGHT:
                    pick = (g + o <= NB - 1) ? mem_b[OW'(g + o)] : reg_b[g];
                MK_STORE_LEFT:
                    pick = (g <= o) ? reg_b[OW'(g + (NB - 1) - o)] : mem_b[g];
                MK_STORE_RIGHT:
                    pick = (g >= o) ? reg_b[OW'(g - o)] : mem_b[g];
                default:
                    pick = mem_b[g];
            endcase
        end

        assign merged[g*8 +: 8] = pick;
    end

endmodule

// File: rtl/umu_rmw_ctrl.sv
// Request capture and bus sequencer. Takes a request while idle, issues a
// one-cycle read of the aligned word, waits for the data, then either
// registers a load result or holds a write of the merged word until it is
// acknowledged. A one-cycle completion pulse ends every operation.
// Assumes the read data is offered for exactly one cycle.
module umu_rmw_ctrl
    import umu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    localparam int NB    = DATA_W / 8,
    localparam int OW    = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_hit,
    input  logic              req_is_store,
    input  merge_kind_e       req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output merge_kind_e       cur_kind,
    output logic [OW-1:0]     cur_off,
    output logic [DATA_W-1:0] cur_data,
    input  logic [DATA_W-1:0] merged,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_rd_valid,
    input  logic              mem_wr_ack,
    output logic              ld_we,
    output logic [IDX_W-1:0]  ld_dst,
    output logic [DATA_W-1:0] ld_data,
    output logic              done
);

    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(NB - 1);

    seq_state_e        state;
    logic              store_q;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;
    logic              ld_we_q;
    logic [IDX_W-1:0]  dst_q;
    logic [DATA_W-1:0] ld_data_q;

    // Sequencer state, request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            store_q   <= 1'b0;
            cur_kind  <= MK_LOAD_LEFT;
            cur_off   <= '0;
            cur_data  <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            done_q    <= 1'b0;
            ld_we_q   <= 1'b0;
            dst_q     <= '0;
            ld_data_q <= '0;
        end else begin
            done_q  <= 1'b0;
            ld_we_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid && req_hit) begin
                        store_q  <= req_is_store;
                        cur_kind <= req_kind;
                        cur_off  <= req_addr[OW-1:0];
                        cur_data <= req_data;
                        addr_q   <= req_addr & ALIGN_MASK;
                        dst_q    <= req_dst;
                        state    <= ST_RD;
                    end
                end
                ST_RD, ST_WAIT: begin
                    if (mem_rd_valid) begin
                        if (store_q) begin
                            wdata_q <= merged;
                            state   <= ST_WR;
                        end else begin
                            ld_data_q <= merged;
                            ld_we_q   <= (dst_q != '0);
                            done_q    <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WR: begin
                    if (mem_wr_ack) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus and result outputs decoded from state and registers
    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_rd_req  = (state == ST_RD);
        mem_wr_req  = (state == ST_WR);
        mem_addr    = addr_q;
        mem_wr_data = wdata_q;
        ld_we       = ld_we_q;
        ld_dst      = dst_q;
        ld_data     = ld_data_q;
        done        = done_q;
    end

endmodule

// File: rtl/unaligned_merge_unit.sv
// Top level of the unaligned word merge unit: opcode decode, sequencer and
// byte-lane merge network. Loads return a merged register value; stores
// perform a read-modify-write of the aligned word.
// Assumes a single outstanding bus access at a time.
module unaligned_merge_unit
    import umu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    localparam int NB    = DATA_W / 8,
    localparam int OW    = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OPC_W-1:0]  req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_wr_ack,
    output logic              ld_we,
    output logic [IDX_W-1:0]  ld_dst,
    output logic [DATA_W-1:0] ld_data,
    output logic              done
);

    logic              dec_hit;
    logic              dec_store;
    merge_kind_e       dec_kind;
    merge_kind_e       cur_kind;
    logic [OW-1:0]     cur_off;
    logic [DATA_W-1:0] cur_data;
    logic [DATA_W-1:0] merged;

    umu_op_decode u_dec (
        .opcode   (req_op),
        .hit      (dec_hit),
        .is_store (dec_store),
        .kind     (dec_kind)
    );

    umu_rmw_ctrl #(
        .AW     (AW),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_hit      (dec_hit),
        .req_is_store (dec_store),
        .req_kind     (dec_kind),
        .req_addr     (req_addr),
        .req_dst      (req_dst),
        .req_data     (req_data),
        .req_ready    (req_ready),
        .cur_kind     (cur_kind),
        .cur_off      (cur_off),
        .cur_data     (cur_data),
        .merged       (merged),
        .mem_rd_req   (mem_rd_req),
        .mem_wr_req   (mem_wr_req),
        .mem_addr     (mem_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_rd_valid (mem_rd_valid),
        .mem_wr_ack   (mem_wr_ack),
        .ld_we        (ld_we),
        .ld_dst       (ld_dst),
        .ld_data      (ld_data),
        .done         (done)
    );

    umu_lane_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .kind     (cur_kind),
        .off      (cur_off),
        .reg_word (cur_data),
        .mem_word (mem_rd_data),
        .merged   (merged)
    );

endmodule

// File: rtl/umu_checker.sv
// Protocol checker for the unaligned word merge unit, bound to the top.
// Observes only top-level ports.
module umu_checker
    import umu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OPC_W-1:0]  req_op,
    input logic              req_ready,
    input logic              mem_rd_req,
    input logic              mem_wr_req,
    input logic [AW-1:0]     mem_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              mem_wr_ack,
    input logic              ld_we,
    input logic [IDX_W-1:0]  ld_dst,
    input logic              done
);

    logic bad_op;
    assign bad_op = (req_op != OPC_LOAD_LEFT) && (req_op != OPC_LOAD_RIGHT) &&
                    (req_op != OPC_STORE_LEFT) && (req_op != OPC_STORE_RIGHT);

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> (mem_addr[1:0] == 2'b00));

    assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_data) && $stable(mem_addr)));

    assert_ack_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ack) |=> (done && !mem_wr_req));

    assert_zero_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> (ld_dst != '0 && done));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_req && !mem_wr_req));

    assert_ignore_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && bad_op) |=> (req_ready && !mem_rd_req && !done));

endmodule

bind unaligned_merge_unit umu_checker #(
    .AW     (AW),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_umu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_ready   (req_ready),
    .mem_rd_req  (mem_rd_req),
    .mem_wr_req  (mem_wr_req),
    .mem_addr    (mem_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_ack  (mem_wr_ack),
    .ld_we       (ld_we),
    .ld_dst      (ld_dst),
    .done        (done)
);

// File: tb/tb_unaligned_merge_unit.sv
// Bench for the unaligned word merge unit: directed corner cases plus
// seeded random operations with random bus latencies.
module tb_unaligned_merge_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] OP_LL = 6'h22;
    localparam logic [5:0] OP_LR = 6'h26;
    localparam logic [5:0] OP_SL = 6'h2A;
    localparam logic [5:0] OP_SR = 6'h2E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_dst = '0;
    logic [31:0] req_data = '0;
    logic        req_ready;
    logic        mem_rd_req, mem_wr_req;
    logic [31:0] mem_addr, mem_wr_data;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_ack = 1'b0;
    logic        ld_we;
    logic [4:0]  ld_dst;
    logic [31:0] ld_data;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unaligned_merge_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_dst(req_dst), .req_data(req_data),
        .req_ready(req_ready), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_ack(mem_wr_ack), .ld_we(ld_we),
        .ld_dst(ld_dst), .ld_data(ld_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected merge from the shift and mask formulas of R2..R5
    function automatic logic [31:0] expect_word(input logic [5:0] op,
            input logic [1:0] off, input logic [31:0] r, input logic [31:0] m);
        int sh;
        sh = 8 * int'(off);
        case (op)
            OP_LL:   return (r & (32'h00FFFFFF >> sh)) | (m << (24 - sh));
            OP_LR:   return (r & (32'hFFFFFF00 << (24 - sh))) | (m >> sh);
            OP_SL:   return (r >> (24 - sh)) | (m & (32'hFFFFFF00 << sh));
            default: return (r << sh) | (m & (32'h00FFFFFF >> (24 - sh)));
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            OP_LL:   return "R2";
            OP_LR:   return "R3";
            OP_SL:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // One full operation; starts and ends at a falling edge
    task automatic run_op(input logic [5:0] op, input logic [31:0] addr,
                          input logic [4:0] dst, input logic [31:0] rv,
                          input logic [31:0] mv, input int rd_lat, input int ack_lat,
                          output logic [31:0] result);
        logic [31:0] exp, al;
        bit st;
        st  = (op == OP_SL) || (op == OP_SR);
        exp = expect_word(op, addr[1:0], rv, mv);
        al  = {addr[31:2], 2'b00};
        result = 'x;
        chk(req_ready === 1'b1, "R11 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_dst = dst; req_data = rv;
        @(negedge clk);
        req_valid = 1'b0; req_data = $urandom;
        chk(mem_rd_req === 1'b1, "R11 request taken, read issued", {31'd0, mem_rd_req}, 32'd1);
        chk(mem_addr === al, "R1 read address", mem_addr, al);
        for (int i = 0; i < rd_lat; i++) begin
            @(negedge clk);
            chk(mem_rd_req === 1'b0, "R8 read request one cycle", {31'd0, mem_rd_req}, 32'd0);
        end
        mem_rd_valid = 1'b1; mem_rd_data = mv;
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_data = $urandom;
        if (!st) begin
            chk(done === 1'b1, "R8 load done after data", {31'd0, done}, 32'd1);
            chk(ld_we === (dst != 0), "R7 load write enable", {31'd0, ld_we}, {31'd0, dst != 0});
            if (dst != 0) begin
                chk(ld_data === exp, tag_of(op), ld_data, exp);
                chk(ld_dst === dst, "R8 load destination", {27'd0, ld_dst}, {27'd0, dst});
            end
            result = ld_data;
        end else begin
            chk(mem_wr_req === 1'b1, "R8 write issued", {31'd0, mem_wr_req}, 32'd1);
            chk(mem_wr_data === exp, tag_of(op), mem_wr_data, exp);
            chk(mem_addr === al, "R1 write address", mem_addr, al);
            result = mem_wr_data;
            for (int i = 0; i < ack_lat; i++) begin
                @(negedge clk);
                chk(mem_wr_req === 1'b1 && mem_wr_data === exp, "R8 write held",
                    mem_wr_data, exp);
            end
            mem_wr_ack = 1'b1;
            @(negedge clk);
            mem_wr_ack = 1'b0;
            chk(done === 1'b1 && mem_wr_req === 1'b0,
                (ack_lat == 0) ? "R10 same-cycle ack completes" : "R8 done after ack",
                {30'd0, done, mem_wr_req}, 32'd2);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] res;
        logic [5:0] ops [4];
        void'($urandom(32'd20240611));
        ops[0] = OP_LL; ops[1] = OP_LR; ops[2] = OP_SL; ops[3] = OP_SR;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_rd_req === 1'b0 && mem_wr_req === 1'b0 &&
            ld_we === 1'b0 && done === 1'b0, "R12 reset state",
            {27'd0, req_ready, mem_rd_req, mem_wr_req, ld_we, done}, 32'h10);

        // Directed: every op at every offset, fixed patterns
        for (int k = 0; k < 4; k++)
            for (int o = 0; o < 4; o++)
                run_op(ops[k], 32'h0000_1000 + o, 5'd7, 32'hAABB_CCDD,
                       32'h1122_3344, 1, 1, res);

        // R6 edge offsets against literal expectations
        run_op(OP_LL, 32'h0000_2003, 5'd3, 32'hDEAD_BEEF, 32'h5566_7788, 0, 0, res);
        chk(res === 32'h5566_7788, "R6 left load offset 3", res, 32'h5566_7788);
        run_op(OP_LR, 32'h0000_2000, 5'd3, 32'hDEAD_BEEF, 32'h5566_7788, 2, 0, res);
        chk(res === 32'h5566_7788, "R6 right load offset 0", res, 32'h5566_7788);
        run_op(OP_SL, 32'h0000_2003, 5'd3, 32'hCAFE_F00D, 32'h5566_7788, 0, 2, res);
        chk(res === 32'hCAFE_F00D, "R6 left store offset 3", res, 32'hCAFE_F00D);
        run_op(OP_SR, 32'h0000_2000, 5'd3, 32'hCAFE_F00D, 32'h5566_7788, 1, 0, res);
        chk(res === 32'hCAFE_F00D, "R6 right store offset 0", res, 32'hCAFE_F00D);

        // R7 loads to register zero
        run_op(OP_LL, 32'h0000_3001, 5'd0, 32'h0, 32'hFFFF_FFFF, 0, 0, res);
        run_op(OP_LR, 32'h0000_3002, 5'd0, 32'h0, 32'hFFFF_FFFF, 2, 0, res);

        // R9 unknown opcodes are ignored
        for (int j = 0; j < 6; j++) begin
            logic [5:0] bop;
            bop = 6'($urandom);
            if (bop == OP_LL || bop == OP_LR || bop == OP_SL || bop == OP_SR) bop = 6'h23;
            req_valid = 1'b1; req_op = bop; req_addr = $urandom;
            @(negedge clk);
            req_valid = 1'b0;
            for (int c = 0; c < 3; c++) begin
                chk(req_ready === 1'b1 && mem_rd_req === 1'b0 && mem_wr_req === 1'b0 &&
                    done === 1'b0, "R9 ignored opcode",
                    {28'd0, req_ready, mem_rd_req, mem_wr_req, done}, 32'h8);
                @(negedge clk);
            end
        end

        // Random operations, some back to back with the completion pulse
        for (int n = 0; n < 600; n++) begin
            logic [4:0] d;
            d = ($urandom % 8 == 0) ? 5'd0 : 5'($urandom);
            run_op(ops[$urandom % 4], $urandom, d, $urandom, $urandom,
                   $urandom % 3, $urandom % 3, res);
            if ($urandom % 2 == 0) begin
                @(negedge clk);
                chk(done === 1'b0 && req_ready === 1'b1, "R11 done single cycle",
                    {30'd0, done, req_ready}, 32'd1);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule